// File: doc/BRIEF.md
# GPIO Output Blink Controller

This block drives a slow square wave onto general-purpose output pins chosen by software. A 32-bit enable register is reached through a simple register port at a fixed offset, with one bit for each pin. A pin blinks when its enable bit is set and its direction input marks it as an output. It then carries a shared blink phase that is high for `HALF_PERIOD` clocks and low for `HALF_PERIOD` clocks. The default `HALF_PERIOD` gives about one blink per second from a 100 MHz clock. Every other pin passes its stored output level through unchanged.

The block never writes the level register. The level is an input here, and it has no effect on a pin while that pin blinks. The enable bits are split across two power domains. Core bits return to their defaults on the core reset. Resume bits return to their defaults only on the resume reset or on a system reset request. One core bit comes out of reset set, so its pin blinks from power-up. Firmware can wire that pin to an LED and clear the bit once boot succeeds.

Top module: `gpio_blink_ctrl`

## Requirements
- R1: After both resets, a read at offset 0x18 returns 0x0004_0000. Pin 18, when it is an output, blinks with phase high at once.
- R2: A write with `reg_we_i` high at offset 0x18 loads the register. Writes at any other offset leave it unchanged. Reads at any other offset return zero.
- R3: Bit positions that are clear in `IMPL_MASK` always read zero. The default mask is 0x1A0F_FFFF, so bits 0 to 19, 25, 27 and 28 are implemented.
- R4: The blink phase is high for `HALF_PERIOD` clocks after the core reset and then alternates low and high, `HALF_PERIOD` clocks each. All blinking pins are in phase.
- R5: A pin with `pin_is_in_i` bit = 1 (input) outputs its `lvl_i` bit whatever its enable bit holds.
- R6: A pin whose enable bit is 0 outputs its `lvl_i` bit. An enabled output pin follows the blink phase whatever its `lvl_i` bit holds.
- R7: Clearing an enable bit returns that pin's output to its `lvl_i` bit in the cycle after the clock edge that takes the write.
- R8: `rst_ni` low restores the core bits (those clear in `RESUME_MASK`) to their defaults. It leaves the resume bits unchanged.
- R9: The resume bits are 25, 27 and 28 (`RESUME_MASK` = 0x1A00_0000) and default to 0. Either `rst_resume_ni` low or a clock edge with `sys_rst_req_i` high restores them, and neither touches the core bits. A system reset request wins over a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Core-domain asynchronous reset, active low |
| rst_resume_ni | input | 1 | Resume-domain asynchronous reset, active low |
| sys_rst_req_i | input | 1 | Synchronous system reset request for resume bits |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register byte offset |
| reg_wdata_i | input | NUM_PINS | Register write data |
| reg_rdata_o | output | NUM_PINS | Register read data, combinational |
| pin_is_in_i | input | NUM_PINS | Direction per pin, 1 = input |
| lvl_i | input | NUM_PINS | Stored output level per pin |
| pad_o | output | NUM_PINS | Resulting pin output value |

## Verification
The assertions assume that `sys_rst_req_i`, `reg_we_i` and `reg_addr_i` are synchronous levels sampled at the rising clock edge. They also assume that each reset, once asserted, is held across at least one rising edge. They treat `pin_is_in_i` and `lvl_i` as register outputs that settle between edges. The bench changes every input only on falling edges and holds each reset low for several cycles, so each sampled value is settled and every reset pulse is seen.

// File: rtl/gpio_blink_pkg.sv
`timescale 1ns/1ps
package gpio_blink_pkg;
  localparam logic [31:0] DEF_IMPL_MASK   = 32'h1A0F_FFFF;
  localparam logic [31:0] DEF_RESUME_MASK = 32'h1A00_0000;
  localparam logic [31:0] DEF_RESET_VAL   = 32'h0004_0000;
  localparam logic [7:0]  DEF_REG_OFFSET  = 8'h18;

  typedef enum logic {PH_LOW = 1'b0, PH_HIGH = 1'b1} blink_ph_e;
endpackage

// File: rtl/gpio_blink_timebase.sv
`timescale 1ns/1ps
module gpio_blink_timebase #(
  parameter int unsigned HALF_PERIOD = 50_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic phase_o
);
  import gpio_blink_pkg::*;

  localparam int unsigned CNT_W = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_PERIOD - 1);

  logic [CNT_W-1:0] cnt_q;
  blink_ph_e        ph_q;
  logic             wrap;

  assign wrap = (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ph_q  <= PH_HIGH;
    end else if (wrap) begin
      cnt_q <= '0;
      ph_q  <= (ph_q == PH_HIGH) ? PH_LOW : PH_HIGH;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign phase_o = (ph_q == PH_HIGH);
endmodule

// File: rtl/gpio_blink_enreg.sv
`timescale 1ns/1ps
module gpio_blink_enreg #(
  parameter int unsigned          NUM_PINS    = 32,
  parameter logic [NUM_PINS-1:0]  IMPL_MASK   = '1,
  parameter logic [NUM_PINS-1:0]  RESUME_MASK = '0,
  parameter logic [NUM_PINS-1:0]  RESET_VAL   = '0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rst_resume_ni,
  input  logic                sys_rst_req_i,
  input  logic                wr_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  output logic [NUM_PINS-1:0] en_o
);
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_bit
    if (!IMPL_MASK[i]) begin : g_none
      logic unused_bit;
      assign unused_bit = wdata_i[i];
      assign en_o[i]    = 1'b0;
    end else if (RESUME_MASK[i]) begin : g_resume
      logic q;
      always_ff @(posedge clk_i or negedge rst_resume_ni) begin
        if (!rst_resume_ni)     q <= RESET_VAL[i];
        else if (sys_rst_req_i) q <= RESET_VAL[i];  // request beats write
        else if (wr_i)          q <= wdata_i[i];
      end
      assign en_o[i] = q;
    end else begin : g_core
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   q <= RESET_VAL[i];
        else if (wr_i) q <= wdata_i[i];
      end
      assign en_o[i] = q;
    end
  end
endmodule

// File: rtl/gpio_blink_mux.sv
`timescale 1ns/1ps
module gpio_blink_mux #(
  parameter int unsigned NUM_PINS = 32
) (
  input  logic                phase_i,
  input  logic [NUM_PINS-1:0] en_i,
  input  logic [NUM_PINS-1:0] pin_is_in_i,
  input  logic [NUM_PINS-1:0] lvl_i,
  output logic [NUM_PINS-1:0] pad_o
);
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic blink_sel;
    assign blink_sel = en_i[i] & ~pin_is_in_i[i];
    assign pad_o[i]  = blink_sel ? phase_i : lvl_i[i];
  end
endmodule

// File: rtl/gpio_blink_ctrl.sv
`timescale 1ns/1ps
module gpio_blink_ctrl #(
  parameter int unsigned          NUM_PINS    = 32,
  parameter int unsigned          ADDR_W      = 8,
  parameter int unsigned          HALF_PERIOD = 50_000_000,
  parameter logic [ADDR_W-1:0]    REG_OFFSET  = ADDR_W'(gpio_blink_pkg::DEF_REG_OFFSET),
  parameter logic [NUM_PINS-1:0]  IMPL_MASK   = NUM_PINS'(gpio_blink_pkg::DEF_IMPL_MASK),
  parameter logic [NUM_PINS-1:0]  RESUME_MASK = NUM_PINS'(gpio_blink_pkg::DEF_RESUME_MASK),
  parameter logic [NUM_PINS-1:0]  RESET_VAL   = NUM_PINS'(gpio_blink_pkg::DEF_RESET_VAL)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rst_resume_ni,
  input  logic                sys_rst_req_i,
  input  logic                reg_we_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [NUM_PINS-1:0] reg_wdata_i,
  output logic [NUM_PINS-1:0] reg_rdata_o,
  input  logic [NUM_PINS-1:0] pin_is_in_i,
  input  logic [NUM_PINS-1:0] lvl_i,
  output logic [NUM_PINS-1:0] pad_o
);
  logic                addr_hit;
  logic                wr_en;
  logic [NUM_PINS-1:0] blink_en;
  logic                blink_phase;

  assign addr_hit = (reg_addr_i == REG_OFFSET);
  assign wr_en    = reg_we_i & addr_hit;

  gpio_blink_timebase #(
    .HALF_PERIOD(HALF_PERIOD)
  ) u_timebase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .phase_o(blink_phase)
  );

  gpio_blink_enreg #(
    .NUM_PINS   (NUM_PINS),
    .IMPL_MASK  (IMPL_MASK),
    .RESUME_MASK(RESUME_MASK),
    .RESET_VAL  (RESET_VAL)
  ) u_enreg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rst_resume_ni(rst_resume_ni),
    .sys_rst_req_i(sys_rst_req_i),
    .wr_i         (wr_en),
    .wdata_i      (reg_wdata_i),
    .en_o         (blink_en)
  );

  gpio_blink_mux #(
    .NUM_PINS(NUM_PINS)
  ) u_mux (
    .phase_i    (blink_phase),
    .en_i       (blink_en),
    .pin_is_in_i(pin_is_in_i),
    .lvl_i      (lvl_i),
    .pad_o      (pad_o)
  );

  assign reg_rdata_o = addr_hit ? blink_en : '0;
endmodule

// File: rtl/gpio_blink_ctrl_chk.sv
`timescale 1ns/1ps
module gpio_blink_ctrl_chk #(
  parameter int unsigned          NUM_PINS    = 32,
  parameter int unsigned          ADDR_W      = 8,
  parameter int unsigned          HALF_PERIOD = 4,
  parameter logic [ADDR_W-1:0]    REG_OFFSET  = '0,
  parameter logic [NUM_PINS-1:0]  IMPL_MASK   = '1,
  parameter logic [NUM_PINS-1:0]  RESUME_MASK = '0,
  parameter logic [NUM_PINS-1:0]  RESET_VAL   = '0
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                rst_resume_ni,
  input logic                sys_rst_req_i,
  input logic                reg_we_i,
  input logic [ADDR_W-1:0]   reg_addr_i,
  input logic [NUM_PINS-1:0] reg_rdata_o,
  input logic [NUM_PINS-1:0] pin_is_in_i,
  input logic [NUM_PINS-1:0] lvl_i,
  input logic [NUM_PINS-1:0] pad_o,
  input logic [NUM_PINS-1:0] en_q_i,
  input logic                phase_i
);
  localparam logic [NUM_PINS-1:0] RES_DEF = RESET_VAL & RESUME_MASK & IMPL_MASK;

  logic        prev_q;
  int unsigned run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b1;
      run_q  <= 0;
    end else begin
      prev_q <= phase_i;
      run_q  <= (phase_i != prev_q) ? 0 : run_q + 1;
    end
  end

  assert_unimpl_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o & ~IMPL_MASK) == '0);

  assert_input_passthru_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_o & pin_is_in_i) == (lvl_i & pin_is_in_i));

  assert_disabled_passthru_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_o & ~en_q_i) == (lvl_i & ~en_q_i));

  assert_blink_in_phase_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_o ^ {NUM_PINS{phase_i}}) & en_q_i & ~pin_is_in_i) == '0);

  assert_phase_no_overrun_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= HALF_PERIOD);

  assert_phase_min_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i != prev_q) |-> (run_q + 1 >= HALF_PERIOD));

  assert_sysrst_resume_R9: assert property (@(posedge clk_i)
    disable iff (!rst_ni || !rst_resume_ni)
    sys_rst_req_i |=> ((en_q_i & RESUME_MASK) == RES_DEF));

  assert_other_addr_ignored_R2: assert property (@(posedge clk_i)
    disable iff (!rst_ni || !rst_resume_ni)
    (reg_we_i && reg_addr_i != REG_OFFSET && !sys_rst_req_i) |=> $stable(en_q_i));
endmodule

bind gpio_blink_ctrl gpio_blink_ctrl_chk #(
  .NUM_PINS   (NUM_PINS),
  .ADDR_W     (ADDR_W),
  .HALF_PERIOD(HALF_PERIOD),
  .REG_OFFSET (REG_OFFSET),
  .IMPL_MASK  (IMPL_MASK),
  .RESUME_MASK(RESUME_MASK),
  .RESET_VAL  (RESET_VAL)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rst_resume_ni(rst_resume_ni),
  .sys_rst_req_i(sys_rst_req_i),
  .reg_we_i     (reg_we_i),
  .reg_addr_i   (reg_addr_i),
  .reg_rdata_o  (reg_rdata_o),
  .pin_is_in_i  (pin_is_in_i),
  .lvl_i        (lvl_i),
  .pad_o        (pad_o),
  .en_q_i       (blink_en),
  .phase_i      (blink_phase)
);

// File: tb/gpio_blink_ctrl_test.sv
`timescale 1ns/1ps
module gpio_blink_ctrl_test;
  localparam int unsigned HP = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rst_resume_ni = 1'b0;
  logic        sys_rst_req_i = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [7:0]  reg_addr_i = 8'h00;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic [31:0] pin_is_in_i = '0;
  logic [31:0] lvl_i = '0;
  logic [31:0] pad_o;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  gpio_blink_ctrl #(.HALF_PERIOD(HP)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .rst_resume_ni(rst_resume_ni),
    .sys_rst_req_i(sys_rst_req_i), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .pin_is_in_i(pin_is_in_i), .lvl_i(lvl_i), .pad_o(pad_o)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [7:0]  wa;
    logic [31:0] wd;
    logic [7:0]  ra;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{4'd3, 8'h18, 32'hFFFF_FFFF, 8'h18, 32'h1A0F_FFFF},
    '{4'd2, 8'h18, 32'h0000_0000, 8'h18, 32'h0000_0000},
    '{4'd2, 8'h10, 32'hFFFF_FFFF, 8'h18, 32'h0000_0000},
    '{4'd2, 8'h18, 32'h0000_00A5, 8'h10, 32'h0000_0000},
    '{4'd3, 8'h18, 32'h1234_5678, 8'h18, 32'h1204_5678},
    '{4'd2, 8'h19, 32'h0000_0000, 8'h18, 32'h1204_5678}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_we_i = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    reg_addr_i = a;
    #1;
    chk(tag, reg_rdata_o, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1; rst_resume_ni = 1'b1;
    // R1: reset value and immediate blink of pin 18
    rd_chk("R1 reset value", 8'h18, 32'h0004_0000);
    // R4: phase high for HP clocks first, then alternates
    for (int k = 0; k < 4 * HP; k++) begin
      chk("R4 blink wave pin18", {31'd0, pad_o[18]}, {31'd0, ((k / HP) % 2) == 0});
      chk("R6 disabled pin follows level", {31'd0, pad_o[0]}, 32'd0);
      @(negedge clk);
    end

    // Register access vectors
    foreach (VECS[i]) begin
      wr(VECS[i].wa, VECS[i].wd);
      rd_chk($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].ra, VECS[i].exp);
    end

    // R4 in phase; R6 level has no effect while blinking
    wr(8'h18, 32'h0004_000F);
    lvl_i = 32'h0000_0005;
    for (int k = 0; k < 2 * HP; k++) begin
      #1;
      chk("R4 pins in phase", {28'd0, pad_o[3:0]}, {28'd0, {4{pad_o[18]}}});
      chk("R6 level ignored while blinking", {31'd0, pad_o[0]}, {31'd0, pad_o[18]});
      @(negedge clk);
    end

    // R5 input pin passes level
    pin_is_in_i = 32'h0000_0001;
    for (int k = 0; k < 2 * HP; k++) begin
      lvl_i[0] = k[0];
      #1;
      chk("R5 input pin passes level", {31'd0, pad_o[0]}, {31'd0, k[0]});
      @(negedge clk);
    end
    pin_is_in_i = '0;

    // R7 clearing returns to level in next cycle
    lvl_i = 32'h0004_0000;
    wr(8'h18, 32'h0000_000F);
    #1;
    chk("R7 cleared pin18 high level", {31'd0, pad_o[18]}, 32'd1);
    lvl_i = 32'h0000_0000;
    wr(8'h18, 32'h0000_0000);
    #1;
    chk("R7 cleared pins low level", {28'd0, pad_o[3:0]}, 32'd0);

    // R8 core reset keeps resume bits
    wr(8'h18, 32'hFFFF_FFFF);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    rd_chk("R8 core reset", 8'h18, 32'h1A04_0000);

    // R9 system reset request clears resume bits only
    wr(8'h18, 32'hFFFF_FFFF);
    @(negedge clk);
    sys_rst_req_i = 1'b1;
    @(negedge clk);
    sys_rst_req_i = 1'b0;
    rd_chk("R9 sys reset request", 8'h18, 32'h000F_FFFF);

    // R9 resume reset
    wr(8'h18, 32'hFFFF_FFFF);
    rst_resume_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_resume_ni = 1'b1;
    rd_chk("R9 resume reset", 8'h18, 32'h000F_FFFF);

    // R9 request wins over same-cycle write
    wr(8'h18, 32'h0000_0000);
    @(negedge clk);
    reg_we_i = 1'b1; reg_addr_i = 8'h18; reg_wdata_i = 32'hFFFF_FFFF; sys_rst_req_i = 1'b1;
    @(negedge clk);
    reg_we_i = 1'b0; sys_rst_req_i = 1'b0;
    rd_chk("R9 request beats write", 8'h18, 32'h000F_FFFF);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule